// File: doc/BRIEF.md
# Packet Parse-Tree Walker

This block classifies a received frame by walking a programmable decision tree stored in a node memory. The frame's leading bytes sit in a 256-byte packet buffer. When a walk is launched, the block begins at a configured node with a configured byte offset. At every decision node it fetches a 16-bit word from the packet at the current offset. It then tests that node's branches one after another with a masked compare. The first valid branch that matches moves the packet offset and names the next node, and the branch at which to begin testing inside that node.

A walk ends in one of four ways. It ends normally when it reaches a node flagged as last, or when no branch of the current node matches. It ends with an error flag when it reaches a node that is not a decision node, or when it runs past the visit limit. In every case the block reports the current node's result pointer together with a one-cycle done pulse. Both memories are read through simple ports with one cycle of read latency, so the block can sit directly beside ordinary synchronous RAMs.

Top module: `ptw_walker`

## Requirements
- R1: While and directly after a synchronous active-high reset, busy, done, walk_err and result_ptr are all 0.
- R2: A start pulse while idle latches the 14-bit start node and the 9-bit start offset, and a walk begins at branch 0 of that node. A start pulse while busy is ignored. Node word w of node n lives at address n*16+w, and both memory ports return data one cycle after the read enable.
- R3: Node word 0 is the header. Its node type is in bits [1:0] (2 = decision node), its last flag is in bit 2, and its 12-bit result pointer is in bits [23:12]. Bits [9:3] are carried but unused here.
- R4: Branch b (0..5) occupies node words 1+2b and 2+2b. The first word holds valid in bit 0, a 9-bit pointer in [9:1], backward in bit 10, relative in bit 11, the operator in [14:12], the next node in [23:15] and the next branch in [28:24]. The second word holds data in [15:0] and mask in [31:16].
- R5: The packet word is big-endian. The byte at (offset mod 256) is the upper byte, and the byte at (offset+1 mod 256) is the lower byte.
- R6: The compare clears every bit set in mask from both the packet word and the data. It then applies the operator: 0 equal, 1 not equal, 2 packet<=data, 3 packet>=data, 4 AND non-zero, 5 AND zero. Codes 6 and 7 never match.
- R7: Branches are tested in increasing index from the entry branch up to branch 5. A branch with valid=0 is skipped, and the first match is taken.
- R8: A taken branch sets the offset modulo 512 as follows. An absolute jump loads the pointer. A relative jump adds the pointer, or subtracts it when backward is set.
- R9: A decision node with the last flag ends the walk with its result pointer and walk_err=0, and none of its branches are tested.
- R10: If no branch matches, or the entry branch is 6 or above, the walk ends with the current node's result pointer and walk_err=0.
- R11: A node whose type is not 2 ends the walk with its own result pointer and walk_err=1, whatever its last flag says.
- R12: A branch taken after 64 node visits ends the walk with walk_err=1 and the 64th node's result pointer. A walk that reaches a last node on its 64th visit ends without error.
- R13: done is a one-cycle pulse, with busy low in that cycle. result_ptr and walk_err change only in a done cycle and hold until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a walk (ignored while busy) |
| cfg_start_node | input | 14 | First node index |
| cfg_start_off | input | 9 | First packet byte offset |
| node_rd_en | output | 1 | Node memory read enable |
| node_rd_addr | output | 18 | Node memory word address |
| node_rd_data | input | 32 | Node memory data, one cycle after enable |
| pkt_rd_en | output | 1 | Packet buffer read enable |
| pkt_rd_addr | output | 8 | Packet buffer byte address |
| pkt_rd_data | input | 8 | Packet byte, one cycle after enable |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| result_ptr | output | 12 | Result pointer of the final node |
| walk_err | output | 1 | Walk ended on a bad node type or the visit limit |

## Verification
The assertions assume that the node memory always answers one cycle after a read, so that no header or branch word is stale. They also assume that reset is applied before the first edge. The bench models both memories as registered arrays that always respond, and it holds reset high from time zero. Start pulses are driven between edges. Some are deliberately placed while a walk is running, so that the no-restart property is exercised under real traffic.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int NODE_SLOTS  = 16;
    localparam int SLOT_W      = $clog2(NODE_SLOTS);
    localparam int BRANCH_MAX  = 6;
    localparam int BR_IDX_W    = 5;

    localparam logic [1:0] NT_DECISION = 2'd2;

    localparam logic [2:0] OP_EQ   = 3'd0;
    localparam logic [2:0] OP_NE   = 3'd1;
    localparam logic [2:0] OP_LE   = 3'd2;
    localparam logic [2:0] OP_GE   = 3'd3;
    localparam logic [2:0] OP_AND  = 3'd4;
    localparam logic [2:0] OP_NAND = 3'd5;

    typedef struct packed {
        logic [7:0]  spare_hi;
        logic [11:0] result;
        logic [1:0]  spare_lo;
        logic [1:0]  srch_store;
        logic [1:0]  byte_sel;
        logic [1:0]  ext_sel;
        logic        len_store;
        logic        last;
        logic [1:0]  ntype;
    } node_hdr_t;

    typedef struct packed {
        logic [2:0]  spare;
        logic [4:0]  nxt_branch;
        logic [8:0]  nxt_node;
        logic [2:0]  op;
        logic        relative;
        logic        backward;
        logic [8:0]  ptr;
        logic        valid;
    } br_ctl_t;

    typedef struct packed {
        logic [15:0] mask;
        logic [15:0] data;
    } br_cmp_t;

    typedef enum logic [2:0] {
        S_IDLE, S_HDR, S_HDRW, S_PLO, S_BRA, S_BRB, S_BRC
    } walk_state_t;

    function automatic logic masked_hit(input logic [2:0] op,
                                        input logic [15:0] word,
                                        input logic [15:0] data,
                                        input logic [15:0] mask);
        logic [15:0] a, b;
        a = word & ~mask;
        b = data & ~mask;
        case (op)
            OP_EQ:   return a == b;
            OP_NE:   return a != b;
            OP_LE:   return a <= b;
            OP_GE:   return a >= b;
            OP_AND:  return (a & b) != 16'd0;
            OP_NAND: return (a & b) == 16'd0;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ptw_match.sv
module ptw_match
    import ptw_pkg::*;
(
    input  br_ctl_t     ctl,
    input  br_cmp_t     cmp,
    input  logic [15:0] word,
    output logic        hit
);
    always_comb begin
        hit = ctl.valid && masked_hit(ctl.op, word, cmp.data, cmp.mask);
    end
endmodule

// File: rtl/ptw_jump.sv
module ptw_jump #(
    parameter int OFF_W = 9
) (
    input  logic [OFF_W-1:0] cur_off,
    input  logic [8:0]       ptr,
    input  logic             backward,
    input  logic             relative,
    output logic [OFF_W-1:0] nxt_off
);
    logic [OFF_W-1:0] step;
    assign step = OFF_W'(ptr);

    always_comb begin
        if (!relative)
            nxt_off = step;
        else if (backward)
            nxt_off = cur_off - step;
        else
            nxt_off = cur_off + step;
    end
endmodule

// File: rtl/ptw_visit_ctr.sv
module ptw_visit_ctr #(
    parameter int MAX_VISITS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic incr,
    output logic at_limit
);
    localparam int CNT_W = $clog2(MAX_VISITS + 1);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (incr && cnt_q != CNT_W'(MAX_VISITS))
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign at_limit = (cnt_q == CNT_W'(MAX_VISITS));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int NODE_W     = 14,
    parameter int OFF_W      = 9,
    parameter int PKT_AW     = 8,
    parameter int MAX_VISITS = 64,
    localparam int NADDR_W   = NODE_W + SLOT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [NODE_W-1:0]  cfg_start_node,
    input  logic [OFF_W-1:0]   cfg_start_off,
    output logic               node_rd_en,
    output logic [NADDR_W-1:0] node_rd_addr,
    input  logic [31:0]        node_rd_data,
    output logic               pkt_rd_en,
    output logic [PKT_AW-1:0]  pkt_rd_addr,
    input  logic [7:0]         pkt_rd_data,
    output logic               busy,
    output logic               done,
    output logic [11:0]        result_ptr,
    output logic               walk_err
);
    walk_state_t           state_q;
    logic [NODE_W-1:0]     node_q;
    logic [OFF_W-1:0]      off_q;
    logic [BR_IDX_W-1:0]   br_q;
    node_hdr_t             hdr_q;
    br_ctl_t               ctl_q;
    logic [7:0]            hi_q, lo_q;
    logic                  done_q, err_q;
    logic [11:0]           res_q;

    logic [SLOT_W-1:0]     ctl_slot, cmp_slot;
    logic [BR_IDX_W-1:0]   br_nxt;
    logic                  hit, at_limit, visit_clr, visit_inc;
    logic [OFF_W-1:0]      jump_off;
    br_cmp_t               cmp_w;

    assign ctl_slot = SLOT_W'({br_q, 1'b0}) + SLOT_W'(1);
    assign cmp_slot = SLOT_W'({br_q, 1'b0}) + SLOT_W'(2);
    assign br_nxt   = br_q + BR_IDX_W'(1);
    assign cmp_w    = br_cmp_t'(node_rd_data);

    ptw_match u_match (
        .ctl  (ctl_q),
        .cmp  (cmp_w),
        .word ({hi_q, lo_q}),
        .hit  (hit)
    );

    ptw_jump #(.OFF_W(OFF_W)) u_jump (
        .cur_off  (off_q),
        .ptr      (ctl_q.ptr),
        .backward (ctl_q.backward),
        .relative (ctl_q.relative),
        .nxt_off  (jump_off)
    );

    assign visit_clr = (state_q == S_IDLE) && start;
    assign visit_inc = (state_q == S_HDRW);

    ptw_visit_ctr #(.MAX_VISITS(MAX_VISITS)) u_visits (
        .clk      (clk),
        .rst      (rst),
        .clear    (visit_clr),
        .incr     (visit_inc),
        .at_limit (at_limit)
    );

    // memory read requests
    always_comb begin
        node_rd_en   = 1'b0;
        node_rd_addr = {node_q, SLOT_W'(0)};
        pkt_rd_en    = 1'b0;
        pkt_rd_addr  = off_q[PKT_AW-1:0];
        case (state_q)
            S_HDR: begin
                node_rd_en = 1'b1;
                pkt_rd_en  = 1'b1;
            end
            S_HDRW: begin
                pkt_rd_en   = 1'b1;
                pkt_rd_addr = off_q[PKT_AW-1:0] + PKT_AW'(1);
            end
            S_BRA: begin
                node_rd_en   = 1'b1;
                node_rd_addr = {node_q, ctl_slot};
            end
            S_BRB: begin
                node_rd_en   = 1'b1;
                node_rd_addr = {node_q, cmp_slot};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            node_q  <= '0;
            off_q   <= '0;
            br_q    <= '0;
            hdr_q   <= '0;
            ctl_q   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            res_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: if (start) begin
                    node_q  <= cfg_start_node;
                    off_q   <= cfg_start_off;
                    br_q    <= '0;
                    state_q <= S_HDR;
                end
                S_HDR: state_q <= S_HDRW;
                S_HDRW: begin
                    hdr_q   <= node_hdr_t'(node_rd_data);
                    hi_q    <= pkt_rd_data;
                    state_q <= S_PLO;
                end
                S_PLO: begin
                    lo_q <= pkt_rd_data;
                    if (hdr_q.ntype != NT_DECISION) begin
                        res_q   <= hdr_q.result;
                        err_q   <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end else if (hdr_q.last ||
                                 br_q >= BR_IDX_W'(BRANCH_MAX)) begin
                        res_q   <= hdr_q.result;
                        err_q   <= 1'b0;
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end else begin
                        state_q <= S_BRA;
                    end
                end
                S_BRA: state_q <= S_BRB;
                S_BRB: begin
                    ctl_q   <= br_ctl_t'(node_rd_data);
                    state_q <= S_BRC;
                end
                S_BRC: begin
                    if (hit) begin
                        if (at_limit) begin
                            res_q   <= hdr_q.result;
                            err_q   <= 1'b1;
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end else begin
                            off_q   <= jump_off;
                            node_q  <= NODE_W'(ctl_q.nxt_node);
                            br_q    <= ctl_q.nxt_branch;
                            state_q <= S_HDR;
                        end
                    end else if (br_nxt >= BR_IDX_W'(BRANCH_MAX)) begin
                        res_q   <= hdr_q.result;
                        err_q   <= 1'b0;
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                    end else begin
                        br_q    <= br_nxt;
                        state_q <= S_BRA;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != S_IDLE);
    assign done       = done_q;
    assign result_ptr = res_q;
    assign walk_err   = err_q;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int NADDR_W = 18
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [11:0]        result_ptr,
    input logic               walk_err,
    input logic               node_rd_en,
    input logic [NADDR_W-1:0] node_rd_addr
);
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R13: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_result_hold_R13: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result_ptr) && $stable(walk_err)));

    assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_fetch_in_walk_R2: assert property (@(posedge clk) disable iff (rst)
        node_rd_en |-> busy);

    assert_slot_range_R4: assert property (@(posedge clk) disable iff (rst)
        node_rd_en |-> (node_rd_addr[3:0] <= 4'd12));
endmodule

bind ptw_walker ptw_walker_chk #(.NADDR_W(NADDR_W)) u_ptw_walker_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .result_ptr   (result_ptr),
    .walk_err     (walk_err),
    .node_rd_en   (node_rd_en),
    .node_rd_addr (node_rd_addr)
);

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [13:0] cfg_start_node = '0;
    logic [8:0]  cfg_start_off = '0;
    logic        node_rd_en;
    logic [17:0] node_rd_addr;
    logic [31:0] node_rd_data = '0;
    logic        pkt_rd_en;
    logic [7:0]  pkt_rd_addr;
    logic [7:0]  pkt_rd_data = '0;
    logic        busy, done, walk_err;
    logic [11:0] result_ptr;

    int checks = 0, failures = 0, n_done = 0, n_pushed = 0, cycles = 0;
    logic [31:0] nmem [int];
    logic [7:0]  pmem [256];
    logic [12:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    ptw_walker i_ptw_walker (
        .clk(clk), .rst(rst), .start(start),
        .cfg_start_node(cfg_start_node), .cfg_start_off(cfg_start_off),
        .node_rd_en(node_rd_en), .node_rd_addr(node_rd_addr),
        .node_rd_data(node_rd_data),
        .pkt_rd_en(pkt_rd_en), .pkt_rd_addr(pkt_rd_addr),
        .pkt_rd_data(pkt_rd_data),
        .busy(busy), .done(done), .result_ptr(result_ptr),
        .walk_err(walk_err)
    );

    function automatic logic [31:0] nrd(input int a);
        return nmem.exists(a) ? nmem[a] : 32'd0;
    endfunction

    always @(posedge clk) begin
        if (node_rd_en) node_rd_data <= nrd(int'(node_rd_addr));
        if (pkt_rd_en)  pkt_rd_data  <= pmem[pkt_rd_addr];
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop expected result on each done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            n_done++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R13 unexpected done", {19'd0, walk_err, result_ptr}, 32'd0);
            end else begin
                logic [12:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({walk_err, result_ptr} == e, t,
                      {19'd0, walk_err, result_ptr}, {19'd0, e});
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            failures++;
            $display("FAIL watchdog R13 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // stimulus builders, bit positions from R3 and R4
    task automatic set_hdr(input int n, input int ntype, input bit last,
                           input int res);
        nmem[n*16] = (32'(res) << 12) | (32'(last) << 2) | 32'(ntype & 3);
    endtask

    task automatic set_br(input int n, input int b, input bit valid,
                          input int ptr, input bit back, input bit rel,
                          input int op, input int nn, input int nb,
                          input int data, input int mask);
        nmem[n*16 + 1 + 2*b] = (32'(nb & 31) << 24) | (32'(nn & 511) << 15) |
                               (32'(op & 7) << 12) | (32'(rel) << 11) |
                               (32'(back) << 10) | (32'(ptr & 511) << 1) |
                               32'(valid);
        nmem[n*16 + 2 + 2*b] = (32'(mask & 16'hffff) << 16) |
                               32'(data & 16'hffff);
    endtask

    // reference walk written from R2..R12
    function automatic logic [12:0] ref_walk(input int sn, input int so);
        int node, off, entry, visits;
        logic [31:0] h, w0, w1;
        logic [15:0] pw, a, b;
        bit hitb, taken;
        node = sn; off = so; entry = 0; visits = 0;
        while (1) begin
            h = nrd(node*16);
            visits++;
            if (h[1:0] != 2'd2) return {1'b1, h[23:12]};
            if (h[2]) return {1'b0, h[23:12]};
            pw = {pmem[off % 256], pmem[(off + 1) % 256]};
            taken = 0;
            for (int bi = entry; bi < 6 && !taken; bi++) begin
                w0 = nrd(node*16 + 1 + 2*bi);
                w1 = nrd(node*16 + 2 + 2*bi);
                a = pw & ~w1[31:16];
                b = w1[15:0] & ~w1[31:16];
                case (w0[14:12])
                    3'd0: hitb = a == b;
                    3'd1: hitb = a != b;
                    3'd2: hitb = a <= b;
                    3'd3: hitb = a >= b;
                    3'd4: hitb = (a & b) != 0;
                    3'd5: hitb = (a & b) == 0;
                    default: hitb = 0;
                endcase
                if (w0[0] && hitb) begin
                    taken = 1;
                    if (visits >= 64) return {1'b1, h[23:12]};
                    if (!w0[11]) off = int'(w0[9:1]);
                    else if (w0[10]) off = (off - int'(w0[9:1]) + 512) % 512;
                    else off = (off + int'(w0[9:1])) % 512;
                    node = int'(w0[23:15]);
                    entry = int'(w0[28:24]);
                end
            end
            if (!taken) return {1'b0, h[23:12]};
        end
    endfunction

    task automatic expect_push(input int sn, input int so, input string tag);
        exp_q.push_back(ref_walk(sn, so));
        tag_q.push_back(tag);
        n_pushed++;
    endtask

    task automatic wait_done_count(input int target);
        while (n_done < target) @(negedge clk);
    endtask

    task automatic run_walk(input int sn, input int so, input string tag);
        expect_push(sn, so, tag);
        @(negedge clk);
        cfg_start_node = 14'(sn);
        cfg_start_off  = 9'(so);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done_count(n_pushed);
        @(negedge clk);
    endtask

    task automatic clear_tree;
        nmem.delete();
        for (int i = 0; i < 256; i++) pmem[i] = 8'(i * 7 + 3);
    endtask

    initial begin
        clear_tree();
        repeat (3) @(negedge clk);
        check(!busy && !done && !walk_err && result_ptr == 12'd0, "R1 reset",
              {18'd0, busy, done, walk_err, result_ptr}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && result_ptr == 12'd0, "R1 after reset",
              {19'd0, busy, result_ptr}, 32'd0);

        // R9: last node stops before any branch
        set_hdr(3, 2, 1, 12'habc);
        set_br(3, 0, 1, 0, 0, 0, 0, 7, 0, 0, 16'hffff);
        set_hdr(7, 2, 1, 12'h777);
        run_walk(3, 0, "R9 last node");

        // R3 R6 R10 R5: ethertype-like compare at offset 12
        clear_tree();
        pmem[12] = 8'h08; pmem[13] = 8'h00;
        set_hdr(0, 2, 0, 12'h0f0);
        set_hdr(1, 2, 1, 12'h111);
        for (int op = 0; op < 8; op++) begin
            for (int d = 0; d < 3; d++) begin
                set_br(0, 0, 1, 0, 0, 0, op, 1, 0, 16'h0700 + d*16'h0100, 0);
                run_walk(0, 12, "R6 operator");
            end
        end
        set_br(0, 0, 1, 0, 0, 0, 0, 1, 0, 16'h0008, 0);
        run_walk(0, 12, "R5 big-endian miss R10");
        set_br(0, 0, 1, 0, 0, 0, 0, 1, 0, 16'h08ff, 16'h00ff);
        run_walk(0, 12, "R6 partial mask");
        set_br(0, 0, 1, 0, 0, 0, 0, 1, 0, 0, 16'hffff);
        run_walk(0, 40, "R6 full mask accepts any");

        // R7: invalid skipped, first valid match wins
        clear_tree();
        set_hdr(0, 2, 0, 12'h100);
        set_br(0, 0, 0, 0, 0, 0, 0, 4, 0, 0, 16'hffff);
        set_br(0, 1, 1, 0, 0, 0, 1, 5, 0, 0, 16'hffff);
        set_br(0, 2, 1, 0, 0, 0, 0, 6, 0, 0, 16'hffff);
        set_br(0, 3, 1, 0, 0, 0, 0, 7, 0, 0, 16'hffff);
        set_hdr(4, 2, 1, 12'h444); set_hdr(5, 2, 1, 12'h555);
        set_hdr(6, 2, 1, 12'h666); set_hdr(7, 2, 1, 12'h777);
        run_walk(0, 0, "R7 first valid match");
        set_br(0, 5, 1, 0, 0, 0, 0, 4, 0, 0, 16'hffff);
        set_br(0, 2, 1, 0, 0, 0, 7, 6, 0, 0, 16'hffff);
        set_br(0, 3, 1, 0, 0, 0, 6, 7, 0, 0, 16'hffff);
        run_walk(0, 0, "R7 last branch slot R4");

        // R8: jumps steer the next packet word
        clear_tree();
        pmem[16] = 8'h12; pmem[17] = 8'h34;
        pmem[8] = 8'h56;  pmem[9] = 8'h78;
        pmem[100] = 8'h9a; pmem[101] = 8'hbc;
        set_hdr(1, 2, 0, 12'h0e1);
        set_br(1, 0, 1, 0, 0, 0, 0, 2, 0, 16'h1234, 0);
        set_br(1, 1, 1, 0, 0, 0, 0, 3, 0, 16'h5678, 0);
        set_br(1, 2, 1, 0, 0, 0, 0, 4, 0, 16'h9abc, 0);
        set_hdr(2, 2, 1, 12'h222); set_hdr(3, 2, 1, 12'h333);
        set_hdr(4, 2, 1, 12'h444);
        set_hdr(0, 2, 0, 12'h0e0);
        set_br(0, 0, 1, 4, 0, 1, 0, 1, 0, 0, 16'hffff);
        run_walk(0, 12, "R8 relative forward");
        set_br(0, 0, 1, 4, 1, 1, 0, 1, 0, 0, 16'hffff);
        run_walk(0, 12, "R8 relative backward");
        set_br(0, 0, 1, 100, 0, 0, 0, 1, 0, 0, 16'hffff);
        run_walk(0, 12, "R8 absolute");
        set_br(0, 0, 1, 20, 1, 1, 0, 1, 0, 0, 16'hffff);
        pmem[248] = 8'h12; pmem[249] = 8'h34;
        run_walk(0, 12, "R8 backward wrap mod 512");

        // R5: byte index wraps at 256
        clear_tree();
        pmem[255] = 8'haa; pmem[0] = 8'hbb;
        set_hdr(0, 2, 0, 12'h001);
        set_br(0, 0, 1, 0, 0, 0, 0, 1, 0, 16'haabb, 0);
        set_hdr(1, 2, 1, 12'h0bb);
        run_walk(0, 255, "R5 wrap at 255");
        run_walk(0, 511, "R5 offset 511");

        // R7 R10: entry branch from the taken branch
        clear_tree();
        set_hdr(0, 2, 0, 12'h010);
        set_br(0, 0, 1, 0, 0, 0, 0, 1, 2, 0, 16'hffff);
        set_hdr(1, 2, 0, 12'h011);
        set_br(1, 0, 1, 0, 0, 0, 0, 8, 0, 0, 16'hffff);
        set_br(1, 2, 1, 0, 0, 0, 0, 9, 0, 0, 16'hffff);
        set_hdr(8, 2, 1, 12'h888); set_hdr(9, 2, 1, 12'h999);
        run_walk(0, 0, "R7 entry branch 2");
        set_br(0, 0, 1, 0, 0, 0, 0, 1, 6, 0, 16'hffff);
        run_walk(0, 0, "R10 entry branch 6");

        // R11: non-decision node types
        set_hdr(9, 1, 1, 12'h9a9);
        set_br(0, 0, 1, 0, 0, 0, 0, 9, 0, 0, 16'hffff);
        run_walk(0, 0, "R11 key-node type");
        set_hdr(9, 0, 1, 12'h9b9);
        run_walk(0, 0, "R11 invalid type");

        // R12: visit limit, self loop and exact 64-node chain
        clear_tree();
        set_hdr(5, 2, 0, 12'h5a5);
        set_br(5, 0, 1, 0, 0, 0, 0, 5, 0, 0, 16'hffff);
        run_walk(5, 0, "R12 self loop");
        clear_tree();
        for (int n = 0; n < 64; n++) begin
            set_hdr(n, 2, n == 63, 12'h300 + n);
            set_br(n, 0, 1, 0, 0, 0, 0, n + 1, 0, 0, 16'hffff);
        end
        run_walk(0, 0, "R12 64 visits reach last");
        set_hdr(63, 2, 0, 12'h33f);
        set_hdr(64, 2, 1, 12'h340);
        run_walk(0, 0, "R12 65th visit blocked");

        // R2: wide start node, start ignored while busy, result held (R13)
        clear_tree();
        set_hdr(14'h2345, 2, 0, 12'hd00);
        set_br(14'h2345, 0, 1, 0, 0, 0, 0, 10, 0, 0, 16'hffff);
        set_hdr(10, 2, 1, 12'hd10);
        set_hdr(11, 2, 1, 12'hd11);
        expect_push(14'h2345, 0, "R2 start ignored while busy");
        @(negedge clk);
        cfg_start_node = 14'h2345; cfg_start_off = 9'd0; start = 1'b1;
        @(negedge clk);
        cfg_start_node = 14'd11; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done_count(n_pushed);
        repeat (30) @(negedge clk);
        check(n_done == n_pushed && !busy, "R2 single done for busy restart",
              32'(n_done), 32'(n_pushed));
        check(result_ptr == 12'hd10 && !walk_err, "R13 result held",
              {19'd0, walk_err, result_ptr}, 32'h0d10);

        check(exp_q.size() == 0, "R13 all walks completed",
              32'(exp_q.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule